// File: doc/BRIEF.md
# Doorbell Write Formatter

This block takes the doorbell fields of a completed request (an attribute byte, a byte address and a data word) and turns them into one write on a 32-bit little-endian bus. A one-cycle start pulse samples the fields. The attribute byte selects whether a write happens at all and how wide it is: 32, 16 or 8 bits. The block then either offers one write, with word-aligned address, byte enables and lane-placed data, on a valid/ready channel, finishes at once with no bus activity, or flags an error without writing.

The address must be naturally aligned to the selected width. Only the low data bits that match the width reach the bus. A parameter chooses what the lanes outside the byte enables carry: zeros, or copies of the narrow value. The block does not arbitrate the bus and does nothing else with the request.

Top module: `dbell_wr_fmt`

## Requirements
- R1: After reset, `wr_valid_o`, `done_o` and `err_o` are all low.
- R2: If attribute bit 7 is 0 when a start is accepted, `done_o` pulses for one cycle in the cycle after the start. No write is offered and no error is flagged, whatever the other attribute bits, address and data hold.
- R3: If attribute bit 7 is 1 and attribute bits [1:0] equal 3 (the reserved width code), `err_o` pulses for one cycle in the cycle after the start. No write is offered and `done_o` stays low.
- R4: A misaligned address with a legal width flags the error in the same way as R3. A 32-bit write (code 0) needs address bits [1:0] = 0. A 16-bit write (code 1) needs address bit 0 = 0. An 8-bit write (code 2) is always aligned.
- R5: A 32-bit write drives byte enables 4'b1111 and the whole data word.
- R6: A 16-bit write drives byte enables 4'b0011 shifted left by 2 × address bit 1. Data bits [15:0] go to the enabled lanes.
- R7: An 8-bit write drives byte enables 4'b0001 shifted left by address bits [1:0]. Data bits [7:0] go to the enabled lane.
- R8: Data bits above the selected width have no effect on the bus data. Lanes outside the enables carry zero when LANE_REPLICATE=0. When LANE_REPLICATE=1 they carry copies of the low 8 or 16 data bits.
- R9: Attribute bits [6:2] have no effect on any output.
- R10: `wr_valid_o` rises in the cycle after an accepted start. It then stays high, with address, data and enables stable, until the cycle in which `wr_ready_i` is sampled high. In the next cycle `wr_valid_o` is low and `done_o` pulses for one cycle.
- R11: A start while a write is pending is ignored and leaves the pending write unchanged.
- R12: `wr_addr_o` equals the sampled address with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse; samples the doorbell fields |
| attr_i | input | 8 | Attribute byte: bit 7 enables the write, bits [1:0] give the width code |
| addr_i | input | ADDR_W | Doorbell byte address |
| data_i | input | 32 | Doorbell data; the low bits are used |
| wr_valid_o | output | 1 | Write offered on the bus |
| wr_ready_i | input | 1 | Bus accepts the write |
| wr_addr_o | output | ADDR_W | Word-aligned write address |
| wr_data_o | output | 32 | Lane-placed write data |
| wr_be_o | output | 4 | Byte enables, bit n for bits [8n+7:8n] |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bench builds two copies with ADDR_W=32, driven by the same inputs. One copy has LANE_REPLICATE=0 and one has LANE_REPLICATE=1, so every write is checked both with zero-filled idle lanes and with copied idle lanes. The 32-bit address lets the bench check that the high address bits pass through while the low two bits are cleared. Holding `wr_ready_i` low for several cycles keeps a write pending, which makes the hold and stability rule observable and gives a window to inject a start while busy.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

   typedef enum logic [1:0] {
      DB_W32 = 2'd0,
      DB_W16 = 2'd1,
      DB_W8  = 2'd2,
      DB_WRS = 2'd3
   } db_width_e;

   localparam int unsigned ATTR_W       = 8;
   localparam int unsigned ATTR_EN_BIT  = 7;
   localparam logic [ATTR_W-1:0] ATTR_LIVE_MASK = 8'h83;

   typedef struct packed {
      logic      enable;
      db_width_e width;
   } db_attr_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output db_attr_t          attr_o,
   output logic              fault_o
);

   logic [ATTR_W-1:0] live;
   logic              misalign;

   assign live          = attr_i & ATTR_LIVE_MASK;
   assign attr_o.enable = live[ATTR_EN_BIT];
   assign attr_o.width  = db_width_e'(live[1:0]);

   always_comb begin
      unique case (attr_o.width)
         DB_W32:  misalign = |addr_i[1:0];
         DB_W16:  misalign = addr_i[0];
         DB_W8:   misalign = 1'b0;
         default: misalign = 1'b1;
      endcase
   end

   assign fault_o = attr_o.enable & misalign;

endmodule

// File: rtl/dbell_lane_place.sv
module dbell_lane_place
   import dbell_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter bit          LANE_REPLICATE = 1'b1,
   localparam int unsigned LANES         = DATA_W / 8
) (
   input  db_width_e         width_i,
   input  logic [1:0]        offs_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [LANES-1:0]  be_o,
   output logic [DATA_W-1:0] data_o
);

   always_comb begin
      unique case (width_i)
         DB_W32:  be_o = {LANES{1'b1}};
         DB_W16:  be_o = LANES'(4'b0011) << {offs_i[1], 1'b0};
         DB_W8:   be_o = LANES'(4'b0001) << offs_i;
         default: be_o = '0;
      endcase
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] pick;

      always_comb begin
         unique case (width_i)
            DB_W32:  pick = data_i[8*k +: 8];
            DB_W16:  pick = data_i[8*(k%2) +: 8];
            default: pick = data_i[7:0];
         endcase
      end

      if (LANE_REPLICATE) begin : g_copy
         assign data_o[8*k +: 8] = pick;
      end else begin : g_zero
         assign data_o[8*k +: 8] = be_o[k] ? pick : 8'h00;
      end
   end

endmodule

// File: rtl/dbell_wr_fmt.sv
module dbell_wr_fmt
   import dbell_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned DATA_W         = 32,
   parameter bit          LANE_REPLICATE = 1'b1,
   localparam int unsigned LANES         = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [LANES-1:0]  wr_be_o,
   output logic              done_o,
   output logic              err_o
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dbell_wr_fmt: DATA_W must be 32");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("dbell_wr_fmt: ADDR_W must be at least 2");
   end

   db_attr_t          dec;
   logic              fault;
   logic [LANES-1:0]  be_n;
   logic [DATA_W-1:0] data_n;
   logic              accept;

   dbell_decode #(.ADDR_W(ADDR_W)) u_decode (
      .attr_i  (attr_i),
      .addr_i  (addr_i),
      .attr_o  (dec),
      .fault_o (fault)
   );

   dbell_lane_place #(
      .DATA_W         (DATA_W),
      .LANE_REPLICATE (LANE_REPLICATE)
   ) u_place (
      .width_i (dec.width),
      .offs_i  (addr_i[1:0]),
      .data_i  (data_i),
      .be_o    (be_n),
      .data_o  (data_n)
   );

   assign accept = start_i & ~wr_valid_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid_o <= 1'b0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
         wr_be_o    <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (wr_valid_o) begin
            if (wr_ready_i) begin
               wr_valid_o <= 1'b0;
               done_o     <= 1'b1;
            end
         end else if (accept) begin
            if (!dec.enable) begin
               done_o <= 1'b1;
            end else if (fault) begin
               err_o <= 1'b1;
            end else begin
               wr_valid_o <= 1'b1;
               wr_addr_o  <= {addr_i[ADDR_W-1:2], 2'b00};
               wr_data_o  <= data_n;
               wr_be_o    <= be_n;
            end
         end
      end
   end

endmodule

// File: rtl/dbell_wr_fmt_chk.sv
module dbell_wr_fmt_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid_o,
   input logic              wr_ready_i,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic [LANES-1:0]  wr_be_o,
   input logic              done_o,
   input logic              err_o
);

   // R10
   hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                    && $stable(wr_data_o) && $stable(wr_be_o));

   // R10
   done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && wr_ready_i |=> done_o && !wr_valid_o);

   // R3
   err_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !wr_valid_o && !done_o);

   // R7
   enable_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> ($countones(wr_be_o) == 1 || $countones(wr_be_o) == 2
                      || $countones(wr_be_o) == LANES));

   // R12
   word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> wr_addr_o[1:0] == 2'b00);

   // R2
   done_is_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !wr_valid_o);

endmodule

bind dbell_wr_fmt dbell_wr_fmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid_o (wr_valid_o),
   .wr_ready_i (wr_ready_i),
   .wr_addr_o  (wr_addr_o),
   .wr_data_o  (wr_data_o),
   .wr_be_o    (wr_be_o),
   .done_o     (done_o),
   .err_o      (err_o)
);

// File: tb/dbell_wr_fmt_tb.sv
module dbell_wr_fmt_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  attr_i = '0;
   logic [31:0] addr_i = '0;
   logic [31:0] data_i = '0;
   logic        wr_ready_i = 1'b0;

   logic        v0, v1, d0, d1, e0, e1;
   logic [31:0] a0, a1, w0, w1;
   logic [3:0]  b0, b1;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   dbell_wr_fmt #(.ADDR_W(32), .DATA_W(32), .LANE_REPLICATE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .attr_i(attr_i),
      .addr_i(addr_i), .data_i(data_i), .wr_valid_o(v0), .wr_ready_i(wr_ready_i),
      .wr_addr_o(a0), .wr_data_o(w0), .wr_be_o(b0), .done_o(d0), .err_o(e0));

   dbell_wr_fmt #(.ADDR_W(32), .DATA_W(32), .LANE_REPLICATE(1'b1)) u_dut_rep (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .attr_i(attr_i),
      .addr_i(addr_i), .data_i(data_i), .wr_valid_o(v1), .wr_ready_i(wr_ready_i),
      .wr_addr_o(a1), .wr_data_o(w1), .wr_be_o(b1), .done_o(d1), .err_o(e1));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [1:0] off);
      case (w)
         2'd0:    return 4'b1111;
         2'd1:    return off[1] ? 4'b1100 : 4'b0011;
         default: return 4'b0001 << off;
      endcase
   endfunction

   function automatic logic [31:0] exp_data(input logic [1:0] w, input logic [1:0] off,
                                            input logic [31:0] d, input bit rep);
      case (w)
         2'd0:    return d;
         2'd1:    return rep ? {2{d[15:0]}} : ({16'h0, d[15:0]} << (off[1] ? 16 : 0));
         default: return rep ? {4{d[7:0]}} : ({24'h0, d[7:0]} << (8 * off));
      endcase
   endfunction

   task automatic fire(input logic [7:0] at, input logic [31:0] ad, input logic [31:0] dt);
      @(negedge clk);
      attr_i  = at;
      addr_i  = ad;
      data_i  = dt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      attr_i  = 8'h00;
      data_i  = 32'h0;
   endtask

   task automatic t_reset();
      check("R1 valid", {31'h0, v0 | v1}, 32'h0);
      check("R1 done", {31'h0, d0 | d1}, 32'h0);
      check("R1 err", {31'h0, e0 | e1}, 32'h0);
   endtask

   task automatic t_skip(input string tag, input logic [7:0] at, input logic [31:0] ad);
      fire(at, ad, 32'hCAFE_F00D);
      check({tag, " done"}, {30'h0, d0, d1}, 32'h3);
      check({tag, " valid"}, {30'h0, v0, v1}, 32'h0);
      check({tag, " err"}, {30'h0, e0, e1}, 32'h0);
      @(negedge clk);
      check({tag, " pulse"}, {30'h0, d0, d1}, 32'h0);
   endtask

   task automatic t_fault(input string tag, input logic [7:0] at, input logic [31:0] ad);
      fire(at, ad, 32'h1234_5678);
      check({tag, " err"}, {30'h0, e0, e1}, 32'h3);
      check({tag, " valid"}, {30'h0, v0, v1}, 32'h0);
      check({tag, " done"}, {30'h0, d0, d1}, 32'h0);
      @(negedge clk);
      check({tag, " pulse"}, {30'h0, e0, e1}, 32'h0);
   endtask

   task automatic t_write(input string tag, input logic [7:0] at, input logic [31:0] ad,
                          input logic [31:0] dt);
      fire(at, ad, dt);
      check({tag, " R10 valid"}, {30'h0, v0, v1}, 32'h3);
      check({tag, " R12 addr"}, a0, {ad[31:2], 2'b00});
      check({tag, " be"}, {28'h0, b0}, {28'h0, exp_be(at[1:0], ad[1:0])});
      check({tag, " be rep"}, {28'h0, b1}, {28'h0, exp_be(at[1:0], ad[1:0])});
      check({tag, " R8 data zero-fill"}, w0, exp_data(at[1:0], ad[1:0], dt, 1'b0));
      check({tag, " R8 data copy"}, w1, exp_data(at[1:0], ad[1:0], dt, 1'b1));
      repeat (2) @(negedge clk);
      check({tag, " R10 held"}, {30'h0, v0, v1}, 32'h3);
      check({tag, " R10 stable"}, w0, exp_data(at[1:0], ad[1:0], dt, 1'b0));
      check({tag, " R10 no early done"}, {30'h0, d0, d1}, 32'h0);
      wr_ready_i = 1'b1;
      @(negedge clk);
      wr_ready_i = 1'b0;
      check({tag, " R10 done"}, {30'h0, d0, d1}, 32'h3);
      check({tag, " R10 valid drop"}, {30'h0, v0, v1}, 32'h0);
   endtask

   task automatic t_busy_start();
      fire(8'h80, 32'h2000_0040, 32'h0BAD_F00D);
      // R11: start a no-write request while the write is pending
      @(negedge clk);
      attr_i = 8'h00; addr_i = 32'h0000_0003; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R11 no done", {30'h0, d0, d1}, 32'h0);
      check("R11 still valid", {30'h0, v0, v1}, 32'h3);
      check("R11 addr kept", a0, 32'h2000_0040);
      check("R11 data kept", w0, 32'h0BAD_F00D);
      wr_ready_i = 1'b1;
      @(negedge clk);
      wr_ready_i = 1'b0;
      check("R11 done once", {30'h0, d0, d1}, 32'h3);
      @(negedge clk);
      check("R11 no second done", {30'h0, d0, d1}, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         n_fail++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      // R5 full word
      t_write("R5 w32", 8'h80, 32'hA000_1000, 32'hA5A5_1234);
      // R6 half word, both halves, junk upper bits
      t_write("R6 w16 lo", 8'h81, 32'hA000_1000, 32'hDEAD_BEEF);
      t_write("R6 w16 hi", 8'h81, 32'hA000_1002, 32'hDEAD_BEEF);
      // R7 byte, every lane
      for (int k = 0; k < 4; k++)
         t_write("R7 w8", 8'h82, 32'h5000_0000 | k, 32'hFFFF_FF5A + (k << 8));
      // R9 reserved attribute bits set
      t_write("R9 w8 rsv", 8'hFE, 32'h7000_0003, 32'h0000_00C3);
      t_write("R9 w32 rsv", 8'hFC, 32'h7000_0004, 32'h8765_4321);
      // R2 no write, even with bad width or misalignment
      t_skip("R2 off", 8'h00, 32'h0000_0000);
      t_skip("R2 off rsv", 8'h7F, 32'h0000_0001);
      // R3 reserved width code
      t_fault("R3 wrs", 8'h83, 32'h0000_0000);
      // R4 misaligned
      t_fault("R4 w16 odd", 8'h81, 32'h0000_0001);
      t_fault("R4 w32 half", 8'h80, 32'h0000_0002);
      t_fault("R4 w32 byte", 8'h80, 32'h0000_0003);

      t_busy_start();

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule